// File: doc/BRIEF.md
# Daisy-Chained DMA Read Master Port

This block lets a utility unit on a shared memory bus take ownership of that bus and then read memory as a bus master. Several units share one active-low, wired-low request line. Each unit asks for the bus by pulling that line low, and it may only do so after the line has read high. A high line shows that every earlier requester has finished. The bus owner issues one grant, which enters the first unit of a daisy chain. Each unit passes the grant downstream only while it is not requesting itself, so a unit's place in the chain sets its priority.

Once granted, the unit's client can issue reads. Each read pulses an address strobe for one cycle, with the address and a half-select bit driven beside it. The unit then holds a data strobe low and latches the data lines every cycle. The responding target first pulls its wait line low. The data strobe is released one cycle after the wait line is seen high again. The last latched word and the state of the bus error line go back to the client with a one-cycle done pulse. When the client yields, the unit stops pulling the request line, and the grant flows on down the chain.

Top module: `dma_chain_port`

## Requirements
- R1: After reset the port does not pull the request line (`req_drive_o` = 0). Both strobes are high (inactive), `done_o` is 0, and `grant_out_o` follows `grant_in_i`.
- R2: A client that wants the bus (`want_i` = 1) causes `req_drive_o` to rise only at a clock edge where `bus_req_n_i` is sampled high. While the line reads low, the request stays off.
- R3: `grant_out_o` is `grant_in_i` AND NOT `req_drive_o`. A requesting unit blocks the grant from every unit below it.
- R4: `granted_o` is 1 when the port requests and `grant_in_i` is 1. `rd_ready_o` is 1 when the port is granted and no read is in flight. A `rd_go_i` pulse while `rd_ready_o` is 0 is ignored and produces no strobe and no done pulse.
- R5: A read accepted at a clock edge drives `ras_n_o` low for exactly the next cycle. In that cycle `addr_oe_o` is 1 and `addr_o` and `half_o` carry the requested address and half-select.
- R6: `rds_n_o` goes low in the cycle after the address strobe. It stays low until the first edge at which `wait_n_i` is sampled high, stays low for one further cycle, and then returns high.
- R7: Each read yields exactly one single-cycle `done_o` pulse. The pulse carries on `done_data_o` the data sampled at the final strobe cycle. For a target that holds wait low for W cycles, the pulse is high W+3 edges after the accepting edge.
- R8: `done_err_o` is 1 when `err_n_i` is sampled low at the end of the final strobe cycle, and 0 otherwise.
- R9: `yield_i` sampled with no read in flight makes `req_drive_o` fall at that edge. `grant_out_o` then passes the grant down the chain. The request is held for as long as a read is in flight.
- R10: After a unit lower in the chain takes the line, a unit that wants the bus waits with its request off until the line is released, and then requests at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| want_i | input | 1 | Client wants bus ownership |
| yield_i | input | 1 | Client gives the bus back |
| rd_go_i | input | 1 | Start a read (taken only when ready) |
| rd_addr_i | input | AW | Read address |
| rd_half_i | input | 1 | Half-select of the addressed cell |
| rd_ready_o | output | 1 | Granted and idle; a read can start |
| granted_o | output | 1 | Port owns the bus |
| done_o | output | 1 | One-cycle read completion pulse |
| done_data_o | output | DW | Data of the completed read |
| done_err_o | output | 1 | Bus error seen on the completed read |
| bus_req_n_i | input | 1 | Resolved shared request line (active low) |
| req_drive_o | output | 1 | 1 = pull the shared request line low |
| grant_in_i | input | 1 | Grant from upstream in the chain |
| grant_out_o | output | 1 | Grant to downstream in the chain |
| ras_n_o | output | 1 | Read address strobe, active low |
| rds_n_o | output | 1 | Read data strobe, active low |
| addr_oe_o | output | 1 | Address/half-select drive enable |
| addr_o | output | AW | Address to the bus |
| half_o | output | 1 | Half-select to the bus |
| bus_data_i | input | DW | Returned read data |
| wait_n_i | input | 1 | Target wait line, active low |
| err_n_i | input | 1 | Bus error line, active low |

## Verification
When the client's request is held and the request line reads high, the request output rises at the next edge. A yield drops it at the next edge, and the downstream grant follows in the same cycle. For a read started at edge c with a target that waits W cycles, the address strobe falls right after edge c. The data strobe holds from edge c+1 to edge c+W+3, and the done pulse is due right after edge c+W+3. The bench samples every output on the falling clock edge. It tags each expected read result with its due cycle number, and the monitor compares that number with the cycle counter when the done pulse actually appears.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_ADDR = 2'd1,
    RD_DATA = 2'd2,
    RD_LAST = 2'd3
  } rd_state_t;

endpackage

// File: rtl/dma_chain_arb.sv
module dma_chain_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic yield_i,
  input  logic eng_idle_i,
  input  logic bus_req_n_i,
  input  logic grant_in_i,
  output logic req_drive_o,
  output logic grant_out_o,
  output logic granted_o
);

  logic req_q;
  logic req_d;
  logic release_c;
  logic raise_c;
  logic req_en;

  assign release_c = yield_i && eng_idle_i;
  assign raise_c   = want_i && bus_req_n_i;

  always_comb begin
    req_d  = req_q;
    req_en = 1'b0;
    if (req_q) begin
      if (release_c) begin
        req_d  = 1'b0;
        req_en = 1'b1;
      end
    end else if (raise_c) begin
      req_d  = 1'b1;
      req_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_en) begin
      req_q <= req_d;
    end
  end

  assign req_drive_o = req_q;
  assign grant_out_o = grant_in_i && !req_q;
  assign granted_o   = grant_in_i && req_q;

  AST_REQ_ON_FREE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(bus_req_n_i)); // R2

endmodule

// File: rtl/dma_read_seq.sv
module dma_read_seq
  import dma_chain_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          half_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic          wait_n_i,
  input  logic          err_n_i,
  output logic          ras_n_o,
  output logic          rds_n_o,
  output logic          addr_oe_o,
  output logic [AW-1:0] addr_o,
  output logic          half_o,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          err_o
);

  rd_state_t     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          half_q;
  logic [DW-1:0] data_q;
  logic          err_q;
  logic          done_q;
  logic          strobe_c;
  logic          last_c;

  assign strobe_c = (state_q == RD_DATA) || (state_q == RD_LAST);
  assign last_c   = (state_q == RD_LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      RD_IDLE: if (start_i)  state_d = RD_ADDR;
      RD_ADDR:               state_d = RD_DATA;
      RD_DATA: if (wait_n_i) state_d = RD_LAST;
      RD_LAST:               state_d = RD_IDLE;
      default:               state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      half_q <= 1'b0;
    end else if (start_i && (state_q == RD_IDLE)) begin
      addr_q <= addr_i;
      half_q <= half_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (strobe_c) begin
      data_q <= bus_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (last_c) begin
      err_q <= !err_n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= last_c;
    end
  end

  assign ras_n_o   = !(state_q == RD_ADDR);
  assign rds_n_o   = !strobe_c;
  assign addr_oe_o = (state_q == RD_ADDR);
  assign addr_o    = addr_q;
  assign half_o    = half_q;
  assign idle_o    = (state_q == RD_IDLE);
  assign done_o    = done_q;
  assign data_o    = data_q;
  assign err_o     = err_q;

  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_o |=> (ras_n_o && !rds_n_o)); // R5

  AST_RELEASE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rds_n_o) |-> $past(wait_n_i)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

endmodule

// File: rtl/dma_chain_port.sv
module dma_chain_port #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_i,
  input  logic          yield_i,
  input  logic          rd_go_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          rd_half_i,
  output logic          rd_ready_o,
  output logic          granted_o,
  output logic          done_o,
  output logic [DW-1:0] done_data_o,
  output logic          done_err_o,
  input  logic          bus_req_n_i,
  output logic          req_drive_o,
  input  logic          grant_in_i,
  output logic          grant_out_o,
  output logic          ras_n_o,
  output logic          rds_n_o,
  output logic          addr_oe_o,
  output logic [AW-1:0] addr_o,
  output logic          half_o,
  input  logic [DW-1:0] bus_data_i,
  input  logic          wait_n_i,
  input  logic          err_n_i
);

  logic eng_idle;
  logic own_bus;
  logic start_c;

  dma_chain_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_i      (want_i),
    .yield_i     (yield_i),
    .eng_idle_i  (eng_idle),
    .bus_req_n_i (bus_req_n_i),
    .grant_in_i  (grant_in_i),
    .req_drive_o (req_drive_o),
    .grant_out_o (grant_out_o),
    .granted_o   (own_bus)
  );

  assign start_c    = rd_go_i && own_bus && eng_idle;
  assign rd_ready_o = own_bus && eng_idle;
  assign granted_o  = own_bus;

  dma_read_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_c),
    .addr_i     (rd_addr_i),
    .half_i     (rd_half_i),
    .bus_data_i (bus_data_i),
    .wait_n_i   (wait_n_i),
    .err_n_i    (err_n_i),
    .ras_n_o    (ras_n_o),
    .rds_n_o    (rds_n_o),
    .addr_oe_o  (addr_oe_o),
    .addr_o     (addr_o),
    .half_o     (half_o),
    .idle_o     (eng_idle),
    .done_o     (done_o),
    .data_o     (done_data_o),
    .err_o      (done_err_o)
  );

  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go_i && !rd_ready_o) |=> ras_n_o); // R4

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_idle |-> req_drive_o); // R9

endmodule

// File: tb/test_dma_chain_port.sv
module test_dma_chain_port;
  localparam int CLK_P = 10;
  localparam int AW = 24;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0;
  int n_bad = 0;

  // unit A (upstream) and unit B (downstream)
  logic want_a = 0, yield_a = 0, go_a = 0, half_a_in = 0;
  logic want_b = 0, yield_b = 0, go_b = 0, half_b_in = 0;
  logic [AW-1:0] addr_a_in = '0, addr_b_in = '0;
  logic rdy_a, gnt_a, done_a, err_a, req_a, gout_a, ras_a, rds_a, oe_a, half_a;
  logic rdy_b, gnt_b, done_b, err_b, req_b, gout_b, ras_b, rds_b, oe_b, half_b;
  logic [DW-1:0] data_a, data_b;
  logic [AW-1:0] addr_a, addr_b;
  logic grant_src = 0, ext_req = 0;
  logic line_n;
  logic wait_n, err_n;
  logic [DW-1:0] mdata;

  assign line_n = !(req_a || req_b || ext_req);

  wire ras_bus = ras_a && ras_b;
  wire [AW-1:0] addr_bus = oe_a ? addr_a : addr_b;
  wire half_bus = oe_a ? half_a : half_b;

  dma_chain_port #(.AW(AW), .DW(DW)) i_dma_chain_port (
    .clk(clk), .rst_n(rst_n), .want_i(want_a), .yield_i(yield_a),
    .rd_go_i(go_a), .rd_addr_i(addr_a_in), .rd_half_i(half_a_in),
    .rd_ready_o(rdy_a), .granted_o(gnt_a), .done_o(done_a),
    .done_data_o(data_a), .done_err_o(err_a), .bus_req_n_i(line_n),
    .req_drive_o(req_a), .grant_in_i(grant_src), .grant_out_o(gout_a),
    .ras_n_o(ras_a), .rds_n_o(rds_a), .addr_oe_o(oe_a), .addr_o(addr_a),
    .half_o(half_a), .bus_data_i(mdata), .wait_n_i(wait_n), .err_n_i(err_n));

  dma_chain_port #(.AW(AW), .DW(DW)) i_peer (
    .clk(clk), .rst_n(rst_n), .want_i(want_b), .yield_i(yield_b),
    .rd_go_i(go_b), .rd_addr_i(addr_b_in), .rd_half_i(half_b_in),
    .rd_ready_o(rdy_b), .granted_o(gnt_b), .done_o(done_b),
    .done_data_o(data_b), .done_err_o(err_b), .bus_req_n_i(line_n),
    .req_drive_o(req_b), .grant_in_i(gout_a), .grant_out_o(gout_b),
    .ras_n_o(ras_b), .rds_n_o(rds_b), .addr_oe_o(oe_b), .addr_o(addr_b),
    .half_o(half_b), .bus_data_i(mdata), .wait_n_i(wait_n), .err_n_i(err_n));

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a, logic h);
    return {7'd0, a, h} ^ 32'hC3A5_0F1E;
  endfunction

  // responding memory: wait low for mem_w cycles after address strobe
  int mem_w = 1;
  logic mem_err = 0;
  int mcnt;
  logic [AW-1:0] maddr;
  logic mhalf;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_n <= 1'b1; err_n <= 1'b1; mdata <= '0; mcnt <= 0;
      maddr <= '0; mhalf <= 1'b0;
    end else if (!ras_bus) begin
      wait_n <= 1'b0; err_n <= 1'b1; mcnt <= mem_w - 1;
      maddr <= addr_bus; mhalf <= half_bus; mdata <= '1;
    end else if (!wait_n) begin
      if (mcnt == 0) begin
        wait_n <= 1'b1; mdata <= word_of(maddr, mhalf); err_n <= !mem_err;
      end else begin
        mcnt <= mcnt - 1;
      end
    end
  end

  typedef struct {
    logic          unit;
    logic [DW-1:0] data;
    logic          err;
    int            due;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops expected results as done pulses appear
  always @(negedge clk) begin
    if (rst_n && (done_a || done_b)) begin
      if (sb.size() == 0) begin
        chk(0, "R7 unexpected done", {62'd0, done_b, done_a}, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(done_b == e.unit && done_a == !e.unit, "R7 unit", {63'd0, done_b}, {63'd0, e.unit});
        chk((e.unit ? data_b : data_a) == e.data, "R7 data",
            {32'd0, e.unit ? data_b : data_a}, {32'd0, e.data});
        chk((e.unit ? err_b : err_a) == e.err, "R8 error flag",
            {63'd0, e.unit ? err_b : err_a}, {63'd0, e.err});
        chk(cyc == e.due, "R7 latency", cyc, e.due);
      end
    end
  end

  // driver: one read on unit u, target waits w cycles
  task automatic do_read(input logic u, input logic [AW-1:0] a, input logic h,
                         input int w, input logic e);
    int c;
    exp_t x;
    mem_w = w; mem_err = e;
    c = cyc;
    if (u) begin go_b = 1; addr_b_in = a; half_b_in = h; end
    else   begin go_a = 1; addr_a_in = a; half_a_in = h; end
    x.unit = u; x.data = word_of(a, h); x.err = e; x.due = c + w + 4;
    sb.push_back(x);
    @(negedge clk);
    go_a = 0; go_b = 0;
    chk((u ? ras_b : ras_a) == 1'b0, "R5 address strobe low", {63'd0, u ? ras_b : ras_a}, 0);
    chk((u ? oe_b : oe_a) && addr_bus == a && half_bus == h, "R5 address driven",
        {39'd0, addr_bus, half_bus}, {39'd0, a, h});
    @(negedge clk);
    chk((u ? ras_b : ras_a) == 1'b1 && (u ? rds_b : rds_a) == 1'b0, "R5 R6 strobe handover",
        {62'd0, u ? ras_b : ras_a, u ? rds_b : rds_a}, 64'd2);
    repeat (w + 1) @(negedge clk);
    chk((u ? rds_b : rds_a) == 1'b0, "R6 data strobe held one cycle past wait",
        {63'd0, u ? rds_b : rds_a}, 0);
    @(negedge clk);
    chk((u ? rds_b : rds_a) == 1'b1, "R6 data strobe released",
        {63'd0, u ? rds_b : rds_a}, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_a == 0 && req_b == 0, "R1 no request in reset", {62'd0, req_a, req_b}, 0);
    chk(ras_a && rds_a && ras_b && rds_b, "R1 strobes idle", {60'd0, ras_a, rds_a, ras_b, rds_b}, 15);
    rst_n = 1;
    @(negedge clk);
    chk(!done_a && !done_b, "R1 no done", {62'd0, done_a, done_b}, 0);
    chk(gout_a == 0, "R1 grant follows (low)", {63'd0, gout_a}, 0);
    grant_src = 1;
    @(negedge clk);
    chk(gout_a == 1 && gout_b == 1, "R1 R3 grant passes when idle", {62'd0, gout_a, gout_b}, 3);

    // R2: request waits for a free line
    ext_req = 1; want_a = 1;
    repeat (3) @(negedge clk);
    chk(req_a == 0, "R2 no request while line low", {63'd0, req_a}, 0);
    ext_req = 0;
    @(negedge clk);
    chk(req_a == 1, "R2 request once line high", {63'd0, req_a}, 1);
    chk(gnt_a == 1 && rdy_a == 1, "R4 granted and ready", {62'd0, gnt_a, rdy_a}, 3);
    chk(gout_a == 0, "R3 requester blocks downstream", {63'd0, gout_a}, 0);

    // R10: downstream unit waits while A holds line
    want_b = 1;
    repeat (2) @(negedge clk);
    chk(req_b == 0 && gnt_b == 0, "R10 downstream held off", {62'd0, req_b, gnt_b}, 0);

    // R5-R8: reads on A with several wait lengths
    do_read(0, 24'h00_1234, 1'b0, 1, 1'b0);
    do_read(0, 24'hAB_CDEF, 1'b1, 3, 1'b0);
    do_read(0, 24'h00_0EEE, 1'b1, 6, 1'b1);
    do_read(0, 24'hFF_FFFF, 1'b0, 2, 1'b0);

    // R4: go on the ungranted unit is ignored
    go_b = 1; addr_b_in = 24'h55_5555;
    @(negedge clk);
    go_b = 0;
    chk(ras_b == 1 && rds_b == 1, "R4 ignored go, no strobe", {62'd0, ras_b, rds_b}, 3);
    repeat (6) @(negedge clk);
    chk(ras_b == 1 && !done_b, "R4 ignored go, no done", {62'd0, ras_b, done_b}, 2);

    // R9: A yields, grant passes to B
    want_a = 0; yield_a = 1;
    @(negedge clk);
    yield_a = 0;
    chk(req_a == 0 && gout_a == 1, "R9 release passes grant", {62'd0, req_a, gout_a}, 1);
    @(negedge clk);
    chk(req_b == 1 && gnt_b == 1, "R10 downstream takes line after release", {62'd0, req_b, gnt_b}, 3);
    chk(gout_b == 0, "R3 B blocks its downstream", {63'd0, gout_b}, 0);

    do_read(1, 24'h12_3456, 1'b1, 2, 1'b0);

    // R10: A wants again while B holds the line
    want_a = 1;
    repeat (3) @(negedge clk);
    chk(req_a == 0, "R10 upstream waits for line", {63'd0, req_a}, 0);
    want_b = 0; yield_b = 1;
    @(negedge clk);
    yield_b = 0;
    chk(req_b == 0, "R9 B released", {63'd0, req_b}, 0);
    @(negedge clk);
    chk(req_a == 1 && gnt_a == 1, "R10 upstream requests after release", {62'd0, req_a, gnt_a}, 3);
    do_read(0, 24'h0A_0B0C, 1'b0, 4, 1'b1);

    grant_src = 0;
    @(negedge clk);
    chk(gnt_a == 0 && rdy_a == 0, "R4 no grant from source", {62'd0, gnt_a, rdy_a}, 0);

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R7 all results delivered", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule